// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip client and an external asynchronous static RAM of 16-bit words with two byte lanes and an 18-bit word address. The client hands over one request at a time through a valid/ready handshake: a write flag, a word address, write data and a two-bit lane mask. The controller turns each request into a pin sequence in which every datasheet minimum is counted out in whole clock cycles. A read ends with a one-cycle pulse that carries the returned word.

The memory pins are a word address, an active-low and an active-high chip select, active-low write enable and output enable, and one active-low select per byte lane. The shared data bus is split into an output word, its drive enable and the sampled input word. The pad ring resolves these into the tri-state pins. Every timing minimum is given in picoseconds together with the clock period, and the wait counts are rounded up from them.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, memCsN=1, memCs=0, memWeN=1, memOeN=1, memBeN=2'b11, memDqOe=0 and reqReady=1.
- R2: A request is taken on the rising edge at which reqValid and reqReady are both 1. reqReady stays 0 from that edge until the access and any turnaround have finished. A request held valid while reqReady is 0 is not taken and changes no pin.
- R3: A read keeps memCsN=0, memCs=1, memWeN=1 and memOeN=0 for RD_CYC cycles, where RD_CYC is the larger of ceil(45 ns/period) and ceil(45 ns/period). The read data is sampled on the edge that ends this window.
- R4: In rdData, bit i of reqMask selects byte lane i (bit 0 is data 7:0, bit 1 is data 15:8). A lane whose mask bit is 0 returns zero, whatever the bus carries.
- R5: After a read, memOeN=1 and both chip selects are inactive for TA_CYC = ceil(18 ns/period) cycles with the bus released, before reqReady returns to 1.
- R6: A write has three phases, and the selects are active and memOeN=1 in all of them. First comes 1 setup cycle with memWeN=1. Then memWeN=0 for WP_CYC = max(ceil(35 ns/period), ceil(25 ns/period)) cycles. Then a hold of max(1, WC_CYC-1-WP_CYC) cycles with memWeN=1, where WC_CYC = ceil(45 ns/period). The hold is followed by idle.
- R7: memDqOe is 1 only during the three write phases, and memOeN is 1 whenever memDqOe is 1. The write enable pulse begins only after at least TA_CYC cycles with memOeN high.
- R8: memBeN[i] = ~reqMask[i] during the access, so a write changes only the selected lanes. A request with mask 2'b00 keeps both byte selects high and leaves the memory unchanged.
- R9: memAddr equals the request address in every cycle in which the chip selects are active.
- R10: rdValid is 1 for exactly one cycle per read: the cycle after the sampling edge, which is the first turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWData | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rdData | output | 16 | Read data, unselected lanes zero |
| rdValid | output | 1 | One-cycle pulse: rdData valid |
| memAddr | output | 18 | Memory word address |
| memCsN | output | 1 | Active-low chip select |
| memCs | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memBeN | output | 2 | Active-low byte lane selects, bit 0 lower |
| memDqOut | output | 16 | Data driven onto the bus |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data sampled from the bus |

## Verification
Two functions can fall in the same clock cycle. The first is the end of a read's turnaround, when reqReady returns. The second is the acceptance of a request that the client has held valid throughout the busy period. When that held request is a write, it also decides whether the bus drive starts too early. The bench provokes this with back-to-back requests, read followed by write and write followed by read, and keeps reqValid high through the busy period. A per-cycle queue of expected pin states compares the exact cycle of acceptance, the full turnaround and the first driven cycle. A bus model fills unselected lanes with filler bytes, so the result also shows whether lane masking holds.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic selOn;      // chip selects and lane selects active next cycle
    logic weOn;       // write enable low next cycle
    logic oeOn;       // output enable low next cycle
    logic driveOn;    // controller drives the bus next cycle
    logic loadReq;    // take request fields this edge
    logic captureRd;  // sample read data this edge
  } ctrl_strobe_t;

  function automatic int ceilCycles(input int durPs, input int periodPs);
    return (durPs + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 12,
  parameter int TA_CYC = 5,
  parameter int SU_CYC = 1,
  parameter int WP_CYC = 9,
  parameter int HD_CYC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output ctrl_strobe_t ctrl
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, TA_CYC), maxOf(maxOf(SU_CYC, WP_CYC), HD_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LOAD = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HD_LOAD = CNT_W'(HD_CYC - 1);

  ctrl_state_t state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic waitDone;

  assign waitDone = (waitCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext      = state;
    waitCntNext    = waitDone ? waitCnt : waitCnt - 1'b1;
    ctrl.loadReq   = 1'b0;
    ctrl.captureRd = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.loadReq = 1'b1;
          if (reqWrite) begin
            stateNext   = ST_WR_SETUP;
            waitCntNext = SU_LOAD;
          end else begin
            stateNext   = ST_RD_ACCESS;
            waitCntNext = RD_LOAD;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (waitDone) begin
          ctrl.captureRd = 1'b1;
          stateNext      = ST_TURN;
          waitCntNext    = TA_LOAD;
        end
      end
      ST_WR_SETUP: begin
        if (waitDone) begin
          stateNext   = ST_WR_PULSE;
          waitCntNext = WP_LOAD;
        end
      end
      ST_WR_PULSE: begin
        if (waitDone) begin
          stateNext   = ST_WR_HOLD;
          waitCntNext = HD_LOAD;
        end
      end
      ST_WR_HOLD: begin
        if (waitDone) stateNext = ST_IDLE;
      end
      ST_TURN: begin
        if (waitDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // pin strobes are decoded from the next state so the registered pins line up with the state
  always_comb begin
    ctrl.selOn   = (stateNext == ST_RD_ACCESS) || (stateNext == ST_WR_SETUP) ||
                   (stateNext == ST_WR_PULSE)  || (stateNext == ST_WR_HOLD);
    ctrl.weOn    = (stateNext == ST_WR_PULSE);
    ctrl.oeOn    = (stateNext == ST_RD_ACCESS);
    ctrl.driveOn = (stateNext == ST_WR_SETUP) || (stateNext == ST_WR_PULSE) ||
                   (stateNext == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  maskNow;
  logic [DATA_W-1:0] laneBits;

  assign maskNow = ctrl.loadReq ? reqMask : maskQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneBits[l*8 +: 8] = {8{maskQ[l]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      maskQ    <= '0;
      memCsN   <= 1'b1;
      memCs    <= 1'b0;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memBeN   <= '1;
      memDqOe  <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (ctrl.loadReq) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWData;
        maskQ    <= reqMask;
      end
      memCsN  <= ~ctrl.selOn;
      memCs   <= ctrl.selOn;
      memWeN  <= ~ctrl.weOn;
      memOeN  <= ~ctrl.oeOn;
      memBeN  <= ~(maskNow & {LANES{ctrl.selOn}});
      memDqOe <= ctrl.driveOn;
      rdValid <= ctrl.captureRd;
      if (ctrl.captureRd) rdData <= memDqIn & laneBits;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int T_ACC_PS      = 45000,  // address/select to read data
  parameter int T_CYC_PS      = 45000,  // read and write cycle time
  parameter int T_WP_PS       = 35000,  // write window
  parameter int T_DW_PS       = 25000,  // data valid before write end
  parameter int T_AS_PS       = 0,      // address setup before write start
  parameter int T_HZ_PS       = 18000,  // device bus release
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int WC_CYC = maxOf(1, ceilCycles(T_CYC_PS, CLK_PERIOD_PS));
  localparam int RD_CYC = maxOf(ceilCycles(T_ACC_PS, CLK_PERIOD_PS), WC_CYC);
  localparam int TA_CYC = maxOf(1, ceilCycles(T_HZ_PS, CLK_PERIOD_PS));
  localparam int SU_CYC = maxOf(1, ceilCycles(T_AS_PS, CLK_PERIOD_PS));
  localparam int WP_CYC = maxOf(1, maxOf(ceilCycles(T_WP_PS, CLK_PERIOD_PS),
                                         ceilCycles(T_DW_PS, CLK_PERIOD_PS)));
  localparam int HD_CYC = (WC_CYC > SU_CYC + WP_CYC) ? (WC_CYC - SU_CYC - WP_CYC) : 1;

  ctrl_strobe_t ctrl;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .SU_CYC(SU_CYC),
    .WP_CYC(WP_CYC), .HD_CYC(HD_CYC)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ctrl(ctrl)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqMask(reqMask), .memDqIn(memDqIn),
    .memAddr(memAddr), .memCsN(memCsN), .memCs(memCs), .memWeN(memWeN),
    .memOeN(memOeN), .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int T_WP_PS       = 35000,
  parameter int T_DW_PS       = 25000,
  parameter int T_HZ_PS       = 18000
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rdValid,
  input logic memCsN,
  input logic memCs,
  input logic memWeN,
  input logic memOeN,
  input logic memDqOe
);

  localparam int WP_CYC = maxOf(1, maxOf(ceilCycles(T_WP_PS, CLK_PERIOD_PS),
                                         ceilCycles(T_DW_PS, CLK_PERIOD_PS)));
  localparam int TA_CYC = maxOf(1, ceilCycles(T_HZ_PS, CLK_PERIOD_PS));

  logic [7:0] weLowRun;
  logic [7:0] oeHighRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      oeHighRun <= 8'hFF;
    end else begin
      if (memWeN)                 weLowRun <= '0;
      else if (weLowRun != 8'hFF) weLowRun <= weLowRun + 1'b1;
      if (!memOeN)                 oeHighRun <= '0;
      else if (oeHighRun != 8'hFF) oeHighRun <= oeHighRun + 1'b1;
    end
  end

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && !memCs && memWeN && memOeN && !memDqOe));

  assert_read_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(!memOeN && !memCsN && memCs));

  assert_we_selected_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memCs && memOeN && memDqOe));

  assert_we_min_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (int'(weLowRun) >= WP_CYC));

  assert_drive_oe_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  assert_drive_after_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (int'(oeHighRun) >= TA_CYC));

  assert_rdvalid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

bind sram_bus_ctrl sram_ctrl_checker chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .memCsN(memCsN), .memCs(memCs), .memWeN(memWeN), .memOeN(memOeN),
  .memDqOe(memDqOe)
);

// File: tb/sram_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb_top;

  localparam int PER_PS = 4000;
  localparam int RD_N   = (45000 + PER_PS - 1) / PER_PS;
  localparam int TA_N   = (18000 + PER_PS - 1) / PER_PS;
  localparam int WP_N   = (35000 + PER_PS - 1) / PER_PS;
  localparam int WC_N   = (45000 + PER_PS - 1) / PER_PS;
  localparam int HD_N   = (WC_N - 1 - WP_N > 1) ? (WC_N - 1 - WP_N) : 1;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rdValid, memCsN, memCs, memWeN, memOeN, memDqOe;
  logic [15:0] rdData, memDqOut, memDqIn;
  logic [17:0] memAddr;
  logic [1:0]  memBeN;

  always #2 clk = ~clk;

  sram_bus_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData), .reqMask(reqMask),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memCsN(memCsN),
    .memCs(memCs), .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural memory on the pins and golden memory on the requests
  logic [15:0] sram [256];
  logic [15:0] gold [256];
  initial for (int i = 0; i < 256; i++) begin sram[i] = '0; gold[i] = '0; end

  always @* begin
    if (!memCsN && memCs && memWeN && !memOeN)
      memDqIn = {memBeN[1] ? 8'hEE : sram[memAddr[7:0]][15:8],
                 memBeN[0] ? 8'hEE : sram[memAddr[7:0]][7:0]};
    else
      memDqIn = 16'hEEEE;
  end

  typedef struct {
    logic csN, cs, weN, oeN;
    logic [1:0] beN;
    logic dqOe, chkAddr;
    logic [17:0] addr;
    logic [15:0] dq;
    logic ready, rdv;
    logic [15:0] rd;
    string tag;
  } exp_t;

  exp_t expQ[$];

  function automatic exp_t idleExp(string tag);
    exp_t e;
    e.csN = 1; e.cs = 0; e.weN = 1; e.oeN = 1; e.beN = 2'b11; e.dqOe = 0;
    e.chkAddr = 0; e.addr = '0; e.dq = '0; e.ready = 1; e.rdv = 0; e.rd = '0;
    e.tag = tag;
    return e;
  endfunction

  task automatic pushSeq(input logic wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m);
    exp_t e;
    logic [15:0] lm;
    lm = {{8{m[1]}}, {8{m[0]}}};
    e = idleExp("R3 R9");
    e.ready = 0; e.chkAddr = 1; e.addr = a; e.csN = 0; e.cs = 1; e.beN = ~m;
    if (!wr) begin
      e.oeN = 0;
      for (int i = 0; i < RD_N; i++) expQ.push_back(e);
      for (int i = 0; i < TA_N; i++) begin
        exp_t t;
        t = idleExp((i == 0) ? "R4 R10" : "R5");
        t.ready = 0; t.rdv = (i == 0); t.rd = gold[a[7:0]] & lm;
        expQ.push_back(t);
      end
    end else begin
      e.tag = "R6 R7 R8"; e.dqOe = 1; e.dq = d;
      expQ.push_back(e);
      e.weN = 0;
      for (int i = 0; i < WP_N; i++) expQ.push_back(e);
      e.weN = 1;
      for (int i = 0; i < HD_N; i++) expQ.push_back(e);
      gold[a[7:0]] = (gold[a[7:0]] & ~lm) | (d & lm);
    end
  endtask

  logic ovPrev = 0;
  logic [7:0] lastIdx;
  logic [1:0] lastBe;
  logic [15:0] lastDat;

  always @(negedge clk) begin
    if (!done) begin
      logic ovNow;
      exp_t e;
      logic bad;
      ovNow = !memCsN && memCs && !memWeN && (memBeN != 2'b11);
      if (ovPrev && !ovNow) begin
        if (!lastBe[0]) sram[lastIdx][7:0]  = lastDat[7:0];
        if (!lastBe[1]) sram[lastIdx][15:8] = lastDat[15:8];
      end
      if (ovNow) begin
        lastIdx = memAddr[7:0]; lastBe = memBeN;
        lastDat = memDqOe ? memDqOut : 16'hDEAD;
      end
      ovPrev = ovNow;

      e = (expQ.size() > 0) ? expQ.pop_front() : idleExp("R1 R2");
      bad = (memCsN !== e.csN) || (memCs !== e.cs) || (memWeN !== e.weN) ||
            (memOeN !== e.oeN) || (memBeN !== e.beN) || (memDqOe !== e.dqOe) ||
            (reqReady !== e.ready) || (rdValid !== e.rdv) ||
            (e.chkAddr && memAddr !== e.addr) || (e.dqOe && memDqOut !== e.dq) ||
            (e.rdv && rdData !== e.rd);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s cyc=%0d act csN=%b cs=%b weN=%b oeN=%b be=%b oe=%b rdy=%b rdv=%b a=%h dq=%h rd=%h exp csN=%b cs=%b weN=%b oeN=%b be=%b oe=%b rdy=%b rdv=%b a=%h dq=%h rd=%h",
          e.tag, cyc, memCsN, memCs, memWeN, memOeN, memBeN, memDqOe, reqReady, rdValid,
          memAddr, memDqOut, rdData, e.csN, e.cs, e.weN, e.oeN, e.beN, e.dqOe, e.ready,
          e.rdv, e.addr, e.dq, e.rd);
      end
      if (rstN && reqValid && reqReady) pushSeq(reqWrite, reqAddr, reqWData, reqMask);
    end
  end

  always @(posedge clk) cyc++;

  // drives at posedge+1; leaves the task at posedge+1 right after acceptance
  task automatic doReq(input logic wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWData = d; reqMask = m;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    idleCycles(4);                       // R1 observed during reset
    rstN = 1;
    idleCycles(3);                       // R1 after release
    doReq(1, 18'h00010, 16'hA5C3, 2'b11); // R6 full write
    idleCycles(2);
    doReq(0, 18'h00010, 16'h0000, 2'b11); // R3 read
    idleCycles(1);
    doReq(1, 18'h00010, 16'h1177, 2'b01); // R8 lower lane only
    idleCycles(1);
    doReq(0, 18'h00010, 16'h0000, 2'b11);
    doReq(0, 18'h00010, 16'h0000, 2'b10); // R4 upper lane only, back-to-back
    doReq(0, 18'h00010, 16'h0000, 2'b01);
    doReq(1, 18'h00010, 16'hFFFF, 2'b00); // R8 mask 00 leaves memory alone
    doReq(0, 18'h00010, 16'h0000, 2'b11);
    doReq(1, 18'h3FFFF, 16'hBEEF, 2'b11); // R9 top address, write after read
    doReq(1, 18'h00000, 16'h1234, 2'b10);
    doReq(0, 18'h3FFFF, 16'h0000, 2'b11); // read right after write
    doReq(0, 18'h00000, 16'h0000, 2'b11);
    doReq(1, 18'h2AA55, 16'hC0DE, 2'b11);
    doReq(1, 18'h2AA55, 16'h5A00, 2'b10);
    doReq(0, 18'h2AA55, 16'h0000, 2'b11);
    idleCycles(RD_N + TA_N + 4);
    done = 1;
    // R8: memory image on the pins matches the golden image
    checks++;
    for (int i = 0; i < 256; i++) begin
      if (sram[i] !== gold[i]) begin
        fails++;
        $display("FAIL R8 image idx=%0d act=%h exp=%h", i, sram[i], gold[i]);
        break;
      end
    end
    finishRun();
  end

  initial begin
    wait (cyc >= LIMIT);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      finishRun();
    end
  end

endmodule